// File: doc/BRIEF.md
# PIO Block Status and Word Countdown Handler

This block sits on the host side of a serial storage link. It acts on a received programmed-I/O setup frame and then tracks one PIO data block. The frame fields arrive already parsed, with a one-cycle `frame_valid` strobe. On that strobe the block writes the initial status and the error value into the shadow Status and Error registers. It also latches the ending status, the direction bit and the interrupt bit, and it loads a countdown in 16-bit words. The initial status normally shows BSY clear and DRQ set. The ending status normally shows DRQ clear, and BSY may be set again.

After the frame, each CPU access to the data register in the frame's direction removes one word from the countdown. On an outbound (host to device) block these are CPU writes. On an inbound (device to host) block they are CPU reads. When the last word has gone, the block copies the ending status into the shadow Status register one clock later. This is well inside the 400 ns allowed, which is 80 cycles at 200 MHz. If the frame asked for it, the block also raises a one-cycle interrupt pulse. Further frames may follow, one per data block. A frame that arrives while a block is still open replaces it.

The controller has three states. IDLE: no block open and the countdown is zero. XFER: words remain. FINISH: the countdown has just run out and the ending status is due. The transitions are as follows.
- IDLE to XFER on a frame with a nonzero count.
- IDLE to FINISH on a frame with a zero count.
- XFER to FINISH on the access that takes the last word.
- FINISH to IDLE when the ending status is applied.
- From any state, a new frame goes to XFER or FINISH according to its count.

Top module: `pio_shadow_ctl`

## Requirements
- R1: After reset, `shadow_status` equals `RST_STATUS` (default 00h), `shadow_error` is 00h, `words_left` is 0, and `xfer_active`, `end_irq` and `overrun` are all low.
- R2: A `frame_valid` strobe at a clock edge makes the following visible after that same edge:
  - `shadow_status` equals `frame_status` and `shadow_error` equals `frame_error`.
  - `words_left` equals the frame's word count.
  - `xfer_active` is high if that word count is nonzero.
- R3: The word count is the byte count divided by two, rounded up. An odd byte count of 5 gives 3 words.
- R4: While `xfer_active` is high, one access in the frame's direction decrements `words_left` by one at that edge. With `frame_dir`=1 (inbound), `cpu_rd` is the counted strobe. With `frame_dir`=0 (outbound), `cpu_wr` is the counted strobe.
- R5: An access in the opposite direction while words remain is ignored. `words_left`, `shadow_status` and `overrun` are unchanged.
- R6: When the last word is taken at edge N:
  - `words_left` is 0 and `xfer_active` is low after edge N.
  - `shadow_status` equals the frame's ending status after edge N+1.
- R7: `end_irq` is high for exactly the one cycle after edge N+1 when the frame's interrupt bit was 1. It stays low when the bit was 0.
- R8: A data-register access (`cpu_rd` or `cpu_wr`) while `words_left` is 0 and no frame is strobed raises `overrun` for one cycle. The count and the shadow registers are unchanged.
- R9: A frame with a byte count of 0 applies its initial status at edge E. It applies its ending status, and any interrupt, at edge E+1.
- R10: A frame takes priority over a data access in the same cycle and over a pending ending status. The new frame's values are loaded and the older block's remaining words and ending status are dropped.
- R11: Successive frames are each handled the same way, with no state carried over from the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe: a setup frame has been parsed |
| frame_dir | input | 1 | 1 = inbound (CPU reads), 0 = outbound (CPU writes) |
| frame_irq | input | 1 | Request an interrupt when the ending status is applied |
| frame_status | input | STAT_W | Initial status for the shadow Status register |
| frame_end_status | input | STAT_W | Ending status applied when the countdown expires |
| frame_error | input | STAT_W | Value for the shadow Error register |
| frame_bytes | input | BYTE_W | Transfer length in bytes |
| cpu_rd | input | 1 | CPU read of the data register |
| cpu_wr | input | 1 | CPU write of the data register |
| shadow_status | output | STAT_W | Shadow Status register |
| shadow_error | output | STAT_W | Shadow Error register |
| words_left | output | BYTE_W | 16-bit words still to be moved in this block |
| xfer_active | output | 1 | A block is open with words remaining |
| end_irq | output | 1 | One-cycle interrupt when the ending status is applied |
| overrun | output | 1 | One-cycle flag: an access arrived with nothing left to move |

## Verification
The countdown is first driven by directed blocks:
- An inbound block and an outbound block. These show whether the right strobe is counted.
- A block with wrong-direction strobes mixed in. This shows that ignored accesses leave the count untouched.
- Odd, zero and one-word lengths. These separate correct rounding from the off-by-one cases at expiry.

Strobes with nothing outstanding expose the overrun path. A frame landing on top of an access, and one landing in the expiry cycle, show whether the frame wins.

A seeded random phase then mixes frames, reads and writes with short lengths. Expiry, overrun and replacement therefore happen in every order. Each cycle is compared against a model built from the requirements.

// File: rtl/pio_shadow_pkg.sv
package pio_shadow_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_FINISH = 2'd2
    } pio_state_t;
endpackage

// File: rtl/pio_word_counter.sv
module pio_word_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_words,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_words;
        end else if (dec && (count != '0)) begin
            count <= count - ONE;
        end
    end

    assign is_zero = (count == '0);
    assign is_one  = (count == ONE);

    AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !is_zero) |=> (count == $past(count) - ONE)); // R4

    AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && is_zero) |=> is_zero); // R8
endmodule

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
    import pio_shadow_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_in,
    input  logic       load_zero,
    input  logic       step,
    input  logic       last_step,
    output pio_state_t state,
    output logic       busy,
    output logic       apply_end
);
    pio_state_t nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (frame_in) nxt = load_zero ? ST_FINISH : ST_XFER;
            end
            ST_XFER: begin
                if (frame_in)                nxt = load_zero ? ST_FINISH : ST_XFER;
                else if (step && last_step)  nxt = ST_FINISH;
            end
            ST_FINISH: begin
                if (frame_in) nxt = load_zero ? ST_FINISH : ST_XFER;
                else          nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        apply_end = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_XFER:   busy = 1'b1;
            ST_FINISH: apply_end = !frame_in;
            default:   ;
        endcase
    end

    AST_FINISH_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && !frame_in) |=> (state == ST_IDLE)); // R6
endmodule

// File: rtl/pio_shadow_regs.sv
module pio_shadow_regs #(
    parameter int                STAT_W     = 8,
    parameter logic [STAT_W-1:0] RST_STATUS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_in,
    input  logic [STAT_W-1:0] init_status,
    input  logic [STAT_W-1:0] end_status,
    input  logic [STAT_W-1:0] err_in,
    input  logic              irq_req,
    input  logic              apply_end,
    output logic [STAT_W-1:0] shadow_status,
    output logic [STAT_W-1:0] shadow_error,
    output logic [STAT_W-1:0] end_hold,
    output logic              irq_pulse
);
    logic irq_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_status <= RST_STATUS;
            shadow_error  <= '0;
            end_hold      <= '0;
            irq_en        <= 1'b0;
            irq_pulse     <= 1'b0;
        end else begin
            irq_pulse <= 1'b0;
            if (frame_in) begin
                shadow_status <= init_status;
                shadow_error  <= err_in;
                end_hold      <= end_status;
                irq_en        <= irq_req;
            end else if (apply_end) begin
                shadow_status <= end_hold;
                irq_pulse     <= irq_en;
            end
        end
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R7

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_in |=> $stable(shadow_error)); // R5
endmodule

// File: rtl/pio_shadow_ctl.sv
module pio_shadow_ctl
    import pio_shadow_pkg::*;
#(
    parameter int                STAT_W     = 8,
    parameter int                BYTE_W     = 16,
    parameter logic [STAT_W-1:0] RST_STATUS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic              frame_dir,
    input  logic              frame_irq,
    input  logic [STAT_W-1:0] frame_status,
    input  logic [STAT_W-1:0] frame_end_status,
    input  logic [STAT_W-1:0] frame_error,
    input  logic [BYTE_W-1:0] frame_bytes,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [STAT_W-1:0] shadow_status,
    output logic [STAT_W-1:0] shadow_error,
    output logic [BYTE_W-1:0] words_left,
    output logic              xfer_active,
    output logic              end_irq,
    output logic              overrun
);
    localparam int HALF_W = BYTE_W - 1;

    logic [BYTE_W-1:0] load_words;
    logic              dir_q;
    logic              cnt_zero;
    logic              cnt_one;
    logic              step;
    logic              apply_end;
    logic              stray;
    logic [STAT_W-1:0] end_hold;
    pio_state_t        state;

    // bytes to words, rounding an odd byte up
    assign load_words = {1'b0, frame_bytes[BYTE_W-1:1]} + {{HALF_W{1'b0}}, frame_bytes[0]};

    always_ff @(posedge clk) begin
        if (!rst_n)           dir_q <= 1'b0;
        else if (frame_valid) dir_q <= frame_dir;
    end

    assign step  = xfer_active && !frame_valid && (dir_q ? cpu_rd : cpu_wr);
    assign stray = !frame_valid && cnt_zero && (cpu_rd || cpu_wr);

    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= stray;
    end

    pio_word_counter #(.CNT_W(BYTE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_valid),
        .load_words(load_words),
        .dec       (step),
        .count     (words_left),
        .is_zero   (cnt_zero),
        .is_one    (cnt_one)
    );

    pio_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_in (frame_valid),
        .load_zero(load_words == '0),
        .step     (step),
        .last_step(cnt_one),
        .state    (state),
        .busy     (xfer_active),
        .apply_end(apply_end)
    );

    pio_shadow_regs #(.STAT_W(STAT_W), .RST_STATUS(RST_STATUS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_in     (frame_valid),
        .init_status  (frame_status),
        .end_status   (frame_end_status),
        .err_in       (frame_error),
        .irq_req      (frame_irq),
        .apply_end    (apply_end),
        .shadow_status(shadow_status),
        .shadow_error (shadow_error),
        .end_hold     (end_hold),
        .irq_pulse    (end_irq)
    );

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> (shadow_status == $past(frame_status)
                         && shadow_error == $past(frame_error))); // R2

    AST_END_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_one) ##1 !frame_valid |=> (shadow_status == $past(end_hold))); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (words_left == $past(words_left))); // R8

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd3)); // R11
endmodule

// File: tb/pio_shadow_ctl_test.sv
`timescale 1ns/100ps
module pio_shadow_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0, frame_dir = 1'b0, frame_irq = 1'b0;
    logic [7:0]  frame_status = '0, frame_end_status = '0, frame_error = '0;
    logic [15:0] frame_bytes = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  shadow_status, shadow_error;
    logic [15:0] words_left;
    logic        xfer_active, end_irq, overrun;

    always #2.5 clk = ~clk;

    pio_shadow_ctl uut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_dir(frame_dir),
        .frame_irq(frame_irq), .frame_status(frame_status), .frame_end_status(frame_end_status),
        .frame_error(frame_error), .frame_bytes(frame_bytes), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .shadow_status(shadow_status), .shadow_error(shadow_error), .words_left(words_left),
        .xfer_active(xfer_active), .end_irq(end_irq), .overrun(overrun)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    // model state, written from the requirements
    logic [7:0]  m_stat, m_err, m_end;
    logic [15:0] m_rem;
    logic        m_dir, m_irqen, m_busy, m_pend, m_irq, m_ovr;

    function automatic logic [15:0] words_of(input logic [15:0] b);
        return (b >> 1) + {15'd0, b[0]};
    endfunction

    task automatic model_reset();
        m_stat = 8'h00; m_err = 8'h00; m_end = 8'h00; m_rem = 16'd0;
        m_dir = 0; m_irqen = 0; m_busy = 0; m_pend = 0; m_irq = 0; m_ovr = 0;
    endtask

    task automatic model_edge();
        m_irq = 0; m_ovr = 0;
        if (frame_valid) begin
            m_stat = frame_status; m_err = frame_error; m_end = frame_end_status;
            m_irqen = frame_irq; m_dir = frame_dir; m_rem = words_of(frame_bytes);
            m_busy = (m_rem != 0); m_pend = (m_rem == 0);
        end else begin
            if ((cpu_rd || cpu_wr) && m_rem == 0) m_ovr = 1;
            if (m_pend) begin
                m_stat = m_end; m_irq = m_irqen; m_pend = 0;
            end else if (m_busy && (m_dir ? cpu_rd : cpu_wr)) begin
                m_rem = m_rem - 16'd1;
                if (m_rem == 0) begin m_busy = 0; m_pend = 1; end
            end
        end
    endtask

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("shadow_status", {8'd0, shadow_status}, {8'd0, m_stat});
        chk("shadow_error",  {8'd0, shadow_error},  {8'd0, m_err});
        chk("words_left",    words_left, m_rem);
        chk("xfer_active",   {15'd0, xfer_active}, {15'd0, m_busy});
        chk("end_irq",       {15'd0, end_irq}, {15'd0, m_irq});
        chk("overrun",       {15'd0, overrun}, {15'd0, m_ovr});
    endtask

    // called at a negedge: drive, clock, update model, check at next negedge
    task automatic cyc(input logic fv, input logic rd, input logic wr);
        frame_valid = fv; cpu_rd = rd; cpu_wr = wr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        frame_valid = 0; cpu_rd = 0; cpu_wr = 0;
    endtask

    task automatic set_frame(input logic d, input logic ir, input logic [7:0] st,
                             input logic [7:0] es, input logic [7:0] er, input logic [15:0] b);
        frame_dir = d; frame_irq = ir; frame_status = st;
        frame_end_status = es; frame_error = er; frame_bytes = b;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd7;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1"; compare();

        // R2 / R4: inbound block of 8 bytes, reads counted
        tag = "R2"; set_frame(1, 1, 8'h58, 8'h50, 8'h04, 16'd8); cyc(1, 0, 0);
        tag = "R4"; cyc(0, 1, 0); cyc(0, 1, 0);
        // R5: writes in an inbound block are ignored
        tag = "R5"; cyc(0, 0, 1); cyc(0, 0, 1);
        tag = "R4"; cyc(0, 1, 0);
        // R6 / R7: last word, then ending status with interrupt
        tag = "R6"; cyc(0, 1, 0);
        tag = "R7"; cyc(0, 0, 0);
        // R8: accesses with nothing left
        tag = "R8"; cyc(0, 1, 0); cyc(0, 0, 1); cyc(0, 0, 0);

        // R3: outbound odd byte count, no interrupt
        tag = "R3"; set_frame(0, 0, 8'h48, 8'hD0, 8'h00, 16'd5); cyc(1, 0, 0);
        tag = "R5"; cyc(0, 1, 0);
        tag = "R3"; cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
        tag = "R7"; cyc(0, 0, 0); cyc(0, 0, 0);

        // R9: zero-length frame
        tag = "R9"; set_frame(1, 1, 8'h58, 8'h51, 8'h10, 16'd0); cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);

        // R10: frame together with an access, and a frame in the expiry cycle
        tag = "R10"; set_frame(0, 1, 8'h58, 8'h50, 8'h00, 16'd6); cyc(1, 0, 0); cyc(0, 0, 1);
        set_frame(0, 1, 8'h59, 8'h41, 8'h02, 16'd2); cyc(1, 0, 1);
        cyc(0, 0, 1);
        set_frame(1, 0, 8'h5A, 8'h52, 8'h03, 16'd4); cyc(1, 0, 0);
        cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 0, 0); cyc(0, 0, 0);

        // R11: random mix of frames and accesses against the model
        tag = "R11";
        for (int i = 0; i < 4000; i++) begin
            logic fv, rd, wr;
            fv = ($urandom % 12) == 0;
            rd = ($urandom % 3) == 0;
            wr = ($urandom % 3) == 0;
            if (fv) set_frame($urandom % 2, $urandom % 2, 8'($urandom), 8'($urandom),
                              8'($urandom), 16'($urandom % 21));
            cyc(fv, rd, wr);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule